// File: doc/BRIEF.md
# IF Frequency Counter with Search Stop

This block decides whether a tuned station sits on the centre of the intermediate-frequency filter. During a programmable gate it counts IF pulses. Each pulse is a one-cycle strobe that has already been synchronised to the system clock. The pulses decrement a down counter that was preloaded with the count a perfectly centred IF would produce. When the counter wraps from zero to all-ones inside a tolerance window around the gate end, the search-stop flag is raised.

A measurement is armed only while the enable input and the PLL lock indication are both high. Once armed, measurements repeat back to back, and each one closes with a one-cycle done pulse. The sampling time, the centre trim and the window width are captured when each measurement starts. The flag keeps the verdict of the latest completed measurement until the next one closes.

Top module: `ifc_search_stop`

## Requirements
- R1: After reset, `search_stop` and `meas_done` are low.
- R2: No measurement runs and no done pulse appears unless `meas_en` and `pll_lock` are both high. IF pulses arriving while the block is not qualified have no effect.
- R3: One base tick is BASE_DIV clock cycles. The gate is G = 2^`gate_sel` ticks and the window half-width is W = 2^`err_win_sel` ticks. A measurement lasts (G+W)·BASE_DIV cycles, counted from the first cycle after it starts. The next edge raises `meas_done` for exactly one cycle, and a new measurement starts on that same edge.
- R4: The expected pulse count is E = NOM_PER_TICK·G + `centre_trim` − 16, where `centre_trim` 16 means no trim and values run from 0 to 31. E is never less than 1. The counter wraps on the E-th pulse. Its active length is MIN_W + `gate_sel` bits, and a wrap means those bits going from all-zero to all-ones.
- R5: If the first wrap falls in tick index t with max(G−W,0) ≤ t ≤ G+W−1, then `search_stop` is high together with `meas_done`.
- R6: A first wrap before tick max(G−W,0) is a failure. `search_stop` is low with `meas_done`, and a later wrap in the same measurement cannot repair the verdict.
- R7: If no wrap happens before the measurement closes, the result is a failure and `search_stop` is low with `meas_done`.
- R8: If `meas_en` or `pll_lock` falls, `search_stop` is low from the next clock edge on, and the running measurement is abandoned without a done pulse.
- R9: `search_stop` is low during the first measurement after qualification. Between consecutive measurements it holds the last verdict. `gate_sel`, `err_win_sel` and `centre_trim` only take effect at a measurement start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_pulse | input | 1 | Synchronised IF strobe, one per IF period |
| meas_en | input | 1 | Measurement enable |
| pll_lock | input | 1 | PLL in-lock qualifier |
| gate_sel | input | 3 | Sampling time select, G = 2^value ticks |
| centre_trim | input | 5 | Centre-frequency trim, 16 = nominal |
| err_win_sel | input | 2 | Window half-width select, W = 2^value ticks |
| search_stop | output | 1 | High after a measurement whose wrap fell in the window |
| meas_done | output | 1 | One-cycle pulse at the close of each measurement |

## Verification
The bench places the wrapping pulse exactly on the first and last ticks of the window, and one pulse period outside each. An off-by-one in the window bounds or the gate length therefore flips a verdict. The case with the shortest gate and a wide window has G−W negative. Unsigned arithmetic there would wrap the lower bound and reject a good station. Trim is checked in both directions, so a preload that ignores the trim field gets one verdict wrong. Changing the window setting in the middle of a run catches a timer that reads live settings instead of captured ones. Dropping lock catches a flag that lingers or a measurement that keeps running.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ifc_state_e;
endpackage

// File: rtl/ifc_gate_timer.sv
module ifc_gate_timer #(
  parameter int BASE_DIV = 64,
  parameter int SEL_W    = 3,
  parameter int EW_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [SEL_W-1:0] sel_q,
  input  logic [EW_W-1:0]  ew_q,
  output logic             close,
  output logic             in_win
);
  localparam int PRE_W = $clog2(BASE_DIV);
  localparam int G_MAX = 2 ** (2 ** SEL_W - 1);
  localparam int W_MAX = 2 ** (2 ** EW_W - 1);
  localparam int TK_W  = $clog2(G_MAX + W_MAX + 1);

  logic [PRE_W-1:0] pre_q, pre_n;
  logic [TK_W-1:0]  tk_q, tk_n;
  logic [TK_W-1:0]  g_len, w_len, lo_tick, last_tick;
  logic             tick_end;

  always_comb begin
    g_len     = TK_W'(1) << sel_q;
    w_len     = TK_W'(1) << ew_q;
    lo_tick   = (g_len > w_len) ? (g_len - w_len) : '0;
    last_tick = g_len + w_len - TK_W'(1);
    tick_end  = (pre_q == PRE_W'(BASE_DIV - 1));
    close     = run && tick_end && (tk_q == last_tick);
    in_win    = (tk_q >= lo_tick) && (tk_q <= last_tick);
  end

  always_comb begin
    pre_n = pre_q;
    tk_n  = tk_q;
    if (clr) begin
      pre_n = '0;
      tk_n  = '0;
    end else if (run) begin
      if (tick_end) begin
        pre_n = '0;
        tk_n  = tk_q + TK_W'(1);
      end else begin
        pre_n = pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      tk_q  <= '0;
    end else begin
      pre_q <= pre_n;
      tk_q  <= tk_n;
    end
  end

  // R3
  tick_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tk_q <= last_tick));

endmodule

// File: rtl/ifc_down_counter.sv
module ifc_down_counter #(
  parameter int MIN_W = 11,
  parameter int SEL_W = 3,
  localparam int MAX_W = MIN_W + 2 ** SEL_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAX_W-1:0] preload,
  input  logic [SEL_W-1:0] sel_q,
  input  logic             dec,
  output logic             wrap
);
  logic [MAX_W-1:0] cnt_q, cnt_n, mask;

  for (genvar i = 0; i < MAX_W; i++) begin : g_mask
    assign mask[i] = (i < MIN_W + int'(sel_q));
  end

  assign wrap = dec && ((cnt_q & mask) == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load)     cnt_n = preload;
    else if (dec) cnt_n = (cnt_q - MAX_W'(1)) & mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R4
  wrap_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !load) |=> (cnt_q == mask));

endmodule

// File: rtl/ifc_wrap_judge.sv
module ifc_wrap_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wrap,
  input  logic in_win,
  output logic pass
);
  logic seen_q, seen_n, ok_q, ok_n;

  assign pass = ok_q || (!seen_q && wrap && in_win);

  always_comb begin
    seen_n = seen_q;
    ok_n   = ok_q;
    if (clr) begin
      seen_n = 1'b0;
      ok_n   = 1'b0;
    end else if (wrap && !seen_q) begin
      seen_n = 1'b1;
      ok_n   = in_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      seen_q <= seen_n;
      ok_q   <= ok_n;
    end
  end

  // R6
  first_wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clr) |=> (seen_q && ok_q == $past(ok_q)));

endmodule

// File: rtl/ifc_search_stop.sv
module ifc_search_stop #(
  parameter int BASE_DIV     = 64,
  parameter int NOM_PER_TICK = 16,
  parameter int MIN_W        = 11,
  parameter int SEL_W        = 3,
  parameter int EW_W         = 2,
  parameter int CF_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_pulse,
  input  logic             meas_en,
  input  logic             pll_lock,
  input  logic [SEL_W-1:0] gate_sel,
  input  logic [CF_W-1:0]  centre_trim,
  input  logic [EW_W-1:0]  err_win_sel,
  output logic             search_stop,
  output logic             meas_done
);
  import ifc_pkg::*;

  localparam int MAX_W  = MIN_W + 2 ** SEL_W - 1;
  localparam int CF_MID = 2 ** (CF_W - 1);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  ifc_state_e       state_q, state_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic [EW_W-1:0]  ew_q, ew_n;
  logic             flag_q, flag_n, done_q, done_n;
  logic             qual, run, close, in_win, wrap, pass;
  logic             start_fresh, restart, load;
  logic [MAX_W-1:0] preload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  assign qual        = meas_en && pll_lock;
  assign run         = (state_q == ST_RUN);
  assign start_fresh = !run && qual;
  assign restart     = run && qual && close;
  assign load        = start_fresh || restart;

  always_comb begin
    int e;
    e = (NOM_PER_TICK << gate_sel) + int'(centre_trim) - CF_MID;
    if (e < 1) e = 1;
    preload = MAX_W'(e - 1);
  end

  always_comb begin
    state_n = qual ? ST_RUN : ST_IDLE;
    sel_n   = load ? gate_sel : sel_q;
    ew_n    = load ? err_win_sel : ew_q;
    done_n  = restart;
    flag_n  = flag_q;
    if (!qual)            flag_n = 1'b0;
    else if (start_fresh) flag_n = 1'b0;
    else if (restart)     flag_n = pass;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      ew_q    <= '0;
      flag_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      ew_q    <= ew_n;
      flag_q  <= flag_n;
      done_q  <= done_n;
    end
  end

  ifc_gate_timer #(.BASE_DIV(BASE_DIV), .SEL_W(SEL_W), .EW_W(EW_W)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .clr(load), .run(run),
    .sel_q(sel_q), .ew_q(ew_q), .close(close), .in_win(in_win)
  );

  ifc_down_counter #(.MIN_W(MIN_W), .SEL_W(SEL_W)) u_count (
    .clk(clk), .rst_n(rst_i_n), .load(load), .preload(preload),
    .sel_q(sel_q), .dec(if_pulse && run), .wrap(wrap)
  );

  ifc_wrap_judge u_judge (
    .clk(clk), .rst_n(rst_i_n), .clr(load), .wrap(wrap),
    .in_win(in_win), .pass(pass)
  );

  assign search_stop = flag_q;
  assign meas_done   = done_q;

  // R8
  flag_drop_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !qual |=> !search_stop);

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    meas_done |=> !meas_done);

  // R5
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(search_stop) |-> meas_done);

  // R2
  done_qual_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    meas_done |-> $past(qual));

endmodule

// File: tb/sim_ifc_search_stop.sv
module sim_ifc_search_stop;
  localparam int DIV = 64;
  localparam int NOM = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic if_pulse = 1'b0, meas_en = 1'b0, pll_lock = 1'b0;
  logic [2:0] gate_sel = '0;
  logic [4:0] centre_trim = 5'd16;
  logic [1:0] err_win_sel = '0;
  logic search_stop, meas_done;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ifc_search_stop u0 (
    .clk(clk), .rst_n(rst_n), .if_pulse(if_pulse), .meas_en(meas_en),
    .pll_lock(pll_lock), .gate_sel(gate_sel), .centre_trim(centre_trim),
    .err_win_sel(err_win_sel), .search_stop(search_stop), .meas_done(meas_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_meas(input int sel, input int ew, input int cf, input int per,
                          input int ew_mid, input string req);
    int g, w, e, lo, n, wc, exp, done_bad, flag0;
    g  = 1 << sel;
    w  = 1 << ew;
    e  = NOM * g + cf - 16;
    if (e < 1) e = 1;
    lo = (g > w) ? g - w : 0;
    n  = (g + w) * DIV;
    wc = e * per - 1;
    exp = (wc < n && wc / DIV >= lo) ? 1 : 0;
    @(negedge clk);
    meas_en = 1'b0;
    if_pulse = 1'b0;
    repeat (2) @(negedge clk);
    gate_sel = 3'(sel);
    err_win_sel = 2'(ew);
    centre_trim = 5'(cf);
    meas_en = 1'b1;
    pll_lock = 1'b1;
    @(posedge clk);
    done_bad = 0;
    flag0 = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if_pulse = ((c + 1) % per == 0);
      if (c == 10) err_win_sel = 2'(ew_mid);
      @(posedge clk);
      #1;
      if (c == 0) flag0 = search_stop;
      if (meas_done != (c == n - 1)) done_bad++;
    end
    @(negedge clk);
    if_pulse = 1'b0;
    chk({req, " R9 flag low in first measurement"}, flag0, 0);
    chk({req, " R3 done timing"}, done_bad, 0);
    chk({req, " verdict"}, search_stop, exp);
  endtask

  task automatic hold_and_withdraw();
    int dn;
    repeat (100) @(negedge clk);
    chk("R9 flag holds during next measurement", search_stop, 1);
    pll_lock = 1'b0;
    @(posedge clk);
    #1;
    chk("R8 flag drops after lock loss", search_stop, 0);
    dn = 0;
    for (int c = 0; c < 600; c++) begin
      @(posedge clk);
      #1;
      dn += meas_done;
    end
    chk("R8 abandoned run gives no done", dn, 0);
  endtask

  task automatic unqualified(input logic en_v, input logic lk_v, input string req);
    int dn, fl;
    @(negedge clk);
    meas_en = en_v;
    pll_lock = lk_v;
    gate_sel = 3'd0;
    err_win_sel = 2'd0;
    dn = 0;
    fl = 0;
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      if_pulse = (c % 4 == 3);
      @(posedge clk);
      #1;
      dn += meas_done;
      fl += search_stop;
    end
    @(negedge clk);
    if_pulse = 1'b0;
    chk({req, " R2 no done"}, dn, 0);
    chk({req, " R2 flag low"}, fl, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flag after reset", search_stop, 0);
    chk("R1 done after reset", meas_done, 0);

    unqualified(1'b1, 1'b0, "enable without lock");
    unqualified(1'b0, 1'b1, "lock without enable");

    run_meas(2, 1, 16, 4, 1, "R5 centred");
    hold_and_withdraw();
    run_meas(2, 1, 16, 2, 1, "R6 early wrap");
    run_meas(2, 1, 16, 3, 1, "R5 first window tick");
    run_meas(2, 1, 16, 6, 1, "R5 last window tick");
    run_meas(2, 1, 16, 7, 1, "R7 no wrap");
    run_meas(2, 1, 0, 8, 1, "R4 trim low accepts slow IF");
    run_meas(2, 1, 16, 8, 1, "R4 nominal rejects slow IF");
    run_meas(2, 0, 16, 5, 0, "R3 narrow window upper");
    run_meas(2, 0, 16, 3, 0, "R3 narrow window early");
    run_meas(0, 1, 16, 12, 1, "R3 short gate clamp pass");
    run_meas(0, 1, 16, 13, 1, "R7 short gate late");
    run_meas(2, 0, 16, 6, 3, "R9 window captured at start");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule